// File: doc/BRIEF.md
# Serial DAC Write Master

This block is the host-side master that loads 16-bit codes into an external serial voltage-output DAC over a three-wire link: an active-low select, a serial clock and a data line. A code arrives on a valid/ready stream port. Once accepted, the block pulls the select low, waits a setup interval, then shifts the word out most significant bit first on sixteen rising clock edges. After a hold interval it raises the select and keeps it high for a minimum gap before taking the next code.

Every interval is a count of system clock cycles. The counts come from parameters that give the system clock in MHz and the minimum times in nanoseconds, each rounded up to whole cycles. The high and low phases of the serial clock always have the same length, so the duty cycle is exactly 50%. After reset no code is accepted until the power-up wait has elapsed.

Back-pressure: `wr_ready` is high only when the block is idle and the power-up wait is over. A code is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_code` is ignored in every other cycle. A source may hold `wr_valid` high for as long as it likes, and a held request is taken in the first idle cycle.

Top module: `dac_wr_ctrl`

## Requirements
- R1: After reset `wr_ready` stays low for ceil(T_PWRUP_NS*CLK_MHZ/1000) rising edges (2000 at defaults), while `dac_cs_n` stays high and `dac_sclk` low. A held `wr_valid` starts no frame in that time.
- R2: `dac_sclk` is low whenever `dac_cs_n` is high. Within a frame each high phase and each low phase lasts exactly HALF cycles (5 at defaults). HALF is the largest of the pulse width, half the minimum serial period and the data setup time, each in cycles.
- R3: `dac_cs_n` falls on the edge that accepts a code. The first rising `dac_sclk` edge comes exactly SETUP cycles later (5 at defaults).
- R4: After the last high phase of `dac_sclk` ends, `dac_cs_n` stays low for HOLD cycles (5 at defaults) before it rises.
- R5: `dac_sdo` carries bit 15 of the code during the setup interval and the first high phase. It changes only on falling `dac_sclk` edges inside a frame, so bit i is on the line during the (16-i)-th high phase. It holds the last bit (bit 0) through the hold interval.
- R6: Each frame has exactly 16 high phases of `dac_sclk`.
- R7: `wr_ready` is high only in idle after power-up. A code offered while `wr_ready` is low is not taken and does not change the frame in progress.
- R8: `busy` is high from the cycle after acceptance until the block is idle again. `done` is high for exactly one cycle: the first cycle in which `dac_cs_n` is high again.
- R9: Between frames `dac_cs_n` stays high for at least GAP = HALF cycles, with `wr_ready` low and `busy` high during that gap.
- R10: `dac_sdo` is low whenever `dac_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Code offered |
| wr_ready | output | 1 | Block can take a code |
| wr_code | input | 16 | Code to send to the DAC |
| busy | output | 1 | A frame or the gap after it is in progress |
| done | output | 1 | One-cycle pulse when a frame has completed |
| dac_cs_n | output | 1 | Active-low select to the DAC |
| dac_sclk | output | 1 | Serial clock to the DAC |
| dac_sdo | output | 1 | Serial data to the DAC |

## Verification
A wrong bit counter shows up within one frame as a high phase too many or too few. A wrong interval count shows up at the first phase of that kind: a select edge or clock edge lands a cycle early or late. A shift register that is out of step puts the wrong level on `dac_sdo` in the first high phase after the fault. A wrong state shows up as `wr_ready` or `busy` disagreeing with the select line during the gap or at power-up. The bench predicts every output on every cycle, so each of these faults is reported in the cycle it first appears.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LOW   = 3'd3,
    ST_HOLD  = 3'd4,
    ST_GAP   = 3'd5
  } wr_state_t;

  // nanoseconds to whole system cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dac_wr_pwrup.sv
module dac_wr_pwrup #(
  parameter int WAIT_CYC = 2000
) (
  input  logic clk,
  input  logic rst,
  output logic up_ok
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign up_ok = (cnt == LIMIT);
endmodule

// File: rtl/dac_wr_timer.sv
module dac_wr_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dac_wr_shifter.sv
module dac_wr_shifter #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic          shift,
  output logic          msb
);
  logic [DW-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst)        sreg <= '0;
    else if (load)  sreg <= load_word;
    else if (shift) sreg <= {sreg[DW-2:0], 1'b0};
  end

  assign msb = sreg[DW-1];
endmodule

// File: rtl/dac_wr_ctrl.sv
module dac_wr_ctrl
  import dac_wr_pkg::*;
#(
  parameter int DW           = 16,
  parameter int CLK_MHZ      = 100,
  parameter int SCLK_MAX_MHZ = 10,
  parameter int T_PULSE_NS   = 45,
  parameter int T_CSS_NS     = 45,
  parameter int T_CSH_NS     = 45,
  parameter int T_DS_NS      = 40,
  parameter int T_PWRUP_NS   = 20000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_code,
  output logic          busy,
  output logic          done,
  output logic          dac_cs_n,
  output logic          dac_sclk,
  output logic          dac_sdo
);
  localparam int HALF_NS  = (500 + SCLK_MAX_MHZ - 1) / SCLK_MAX_MHZ;
  localparam int HALF_CYC = max3(ns_to_cyc(T_PULSE_NS, CLK_MHZ),
                                 ns_to_cyc(HALF_NS, CLK_MHZ),
                                 ns_to_cyc(T_DS_NS, CLK_MHZ));
  localparam int SET_CYC  = ns_to_cyc(T_CSS_NS, CLK_MHZ);
  localparam int HLD_CYC  = ns_to_cyc(T_CSH_NS, CLK_MHZ);
  localparam int GAP_CYC  = HALF_CYC;
  localparam int PWR_CYC  = ns_to_cyc(T_PWRUP_NS, CLK_MHZ);
  localparam int TMAX     = max3(HALF_CYC, SET_CYC, HLD_CYC);
  localparam int TW       = $clog2(TMAX + 1);
  localparam int BW       = $clog2(DW);

  localparam logic [TW-1:0] LD_HALF = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] LD_SET  = TW'(SET_CYC - 1);
  localparam logic [TW-1:0] LD_HLD  = TW'(HLD_CYC - 1);
  localparam logic [TW-1:0] LD_GAP  = TW'(GAP_CYC - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  wr_state_t     st;
  logic          up_ok, t_exp, t_load, accept, sh_shift, last_bit;
  logic [TW-1:0] t_val;
  logic [BW-1:0] bits_left;

  assign wr_ready = (st == ST_IDLE) && up_ok;
  assign accept   = wr_valid && wr_ready;
  assign busy     = (st != ST_IDLE);
  assign last_bit = (bits_left == '0);

  dac_wr_pwrup #(.WAIT_CYC(PWR_CYC)) u_pwrup (
    .clk   (clk),
    .rst   (rst),
    .up_ok (up_ok)
  );

  dac_wr_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  dac_wr_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_word (wr_code),
    .shift     (sh_shift),
    .msb       (dac_sdo)
  );

  // next interval to time, chosen by the phase that is ending
  always_comb begin
    t_load   = 1'b0;
    t_val    = '0;
    sh_shift = 1'b0;
    unique case (st)
      ST_IDLE: begin
        t_load = accept;
        t_val  = LD_SET;
      end
      ST_SETUP: begin
        t_load = t_exp;
        t_val  = LD_HALF;
      end
      ST_HIGH: begin
        t_load   = t_exp;
        t_val    = last_bit ? LD_HLD : LD_HALF;
        sh_shift = t_exp && !last_bit;
      end
      ST_LOW: begin
        t_load = t_exp;
        t_val  = LD_HALF;
      end
      ST_HOLD: begin
        t_load   = t_exp;
        t_val    = LD_GAP;
        sh_shift = t_exp;
      end
      ST_GAP: begin
        t_load = 1'b0;
        t_val  = '0;
      end
      default: begin
        t_load = 1'b0;
        t_val  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      dac_cs_n  <= 1'b1;
      dac_sclk  <= 1'b0;
      done      <= 1'b0;
      bits_left <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          dac_cs_n <= 1'b0;
          st       <= ST_SETUP;
        end
        ST_SETUP: if (t_exp) begin
          dac_sclk  <= 1'b1;
          bits_left <= LAST_BIT;
          st        <= ST_HIGH;
        end
        ST_HIGH: if (t_exp) begin
          dac_sclk <= 1'b0;
          if (last_bit) st <= ST_HOLD;
          else begin
            bits_left <= bits_left - 1'b1;
            st        <= ST_LOW;
          end
        end
        ST_LOW: if (t_exp) begin
          dac_sclk <= 1'b1;
          st       <= ST_HIGH;
        end
        ST_HOLD: if (t_exp) begin
          dac_cs_n <= 1'b1;
          done     <= 1'b1;
          st       <= ST_GAP;
        end
        ST_GAP: if (t_exp) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_wr_ctrl_chk.sv
module dac_wr_ctrl_chk #(
  parameter int SET_CYC = 5,
  parameter int HLD_CYC = 5,
  parameter int PWR_CYC = 2000
) (
  input logic clk,
  input logic rst,
  input logic wr_valid,
  input logic wr_ready,
  input logic busy,
  input logic done,
  input logic dac_cs_n,
  input logic dac_sclk,
  input logic dac_sdo
);
  int up_cnt, cs_low_run, sclk_low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_cnt       <= 0;
      cs_low_run   <= 0;
      sclk_low_run <= 0;
    end else begin
      if (up_cnt < PWR_CYC) up_cnt <= up_cnt + 1;
      cs_low_run   <= dac_cs_n ? 0 : cs_low_run + 1;
      sclk_low_run <= (dac_cs_n || dac_sclk) ? 0 : sclk_low_run + 1;
    end
  end

  p_pwrup_wait_r1: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> (up_cnt >= PWR_CYC));
  p_idle_clk_low_r2: assert property (@(posedge clk) disable iff (rst)
    dac_cs_n |-> !dac_sclk);
  p_cs_setup_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_sclk) |-> (cs_low_run >= SET_CYC));
  p_cs_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_cs_n) |-> (sclk_low_run >= HLD_CYC));
  p_sdo_stable_high_r5: assert property (@(posedge clk) disable iff (rst)
    (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdo));
  p_sdo_moves_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (!dac_cs_n && !$past(dac_cs_n) && !$stable(dac_sdo)) |-> $fell(dac_sclk));
  p_ready_idle_r7: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> (dac_cs_n && !busy));
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_at_cs_rise_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(dac_cs_n));
  p_busy_frame_r8: assert property (@(posedge clk) disable iff (rst)
    !dac_cs_n |-> busy);
  p_sdo_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    dac_cs_n |-> !dac_sdo);

  logic unused_ok;
  assign unused_ok = wr_valid;
endmodule

bind dac_wr_ctrl dac_wr_ctrl_chk #(
  .SET_CYC (SET_CYC),
  .HLD_CYC (HLD_CYC),
  .PWR_CYC (PWR_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .busy     (busy),
  .done     (done),
  .dac_cs_n (dac_cs_n),
  .dac_sclk (dac_sclk),
  .dac_sdo  (dac_sdo)
);

// File: tb/dac_wr_ctrl_tb.sv
module dac_wr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  // expected counts at 100 MHz, worked out from the requirements
  localparam int E_HALF = 5;
  localparam int E_SET  = 5;
  localparam int E_HLD  = 5;
  localparam int E_GAP  = 5;
  localparam int E_PWR  = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic [15:0] wr_code = '0;
  logic wr_ready, busy, done, dac_cs_n, dac_sclk, dac_sdo;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int pu     = 0;
  int rises  = 0;
  bit started = 1'b0;

  // expected {cs_n, sclk, sdo, ready, busy, done}
  logic [5:0] cur;
  logic [5:0] q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_wr_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_code(wr_code), .busy(busy), .done(done),
    .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo)
  );

  task automatic push_frame(input logic [15:0] c);
    for (int k = 0; k < E_SET; k++) q.push_back({1'b0, 1'b0, c[15], 3'b010});
    for (int i = 15; i >= 0; i--) begin
      for (int k = 0; k < E_HALF; k++) q.push_back({1'b0, 1'b1, c[i], 3'b010});
      if (i > 0)
        for (int k = 0; k < E_HALF; k++) q.push_back({1'b0, 1'b0, c[i-1], 3'b010});
    end
    for (int k = 0; k < E_HLD; k++) q.push_back({1'b0, 1'b0, c[0], 3'b010});
    for (int k = 0; k < E_GAP; k++) q.push_back({1'b1, 1'b0, 1'b0, 2'b01, (k == 0)});
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      pu = 0;
      q.delete();
      cur = 6'b100000;
    end else begin
      if (pu < E_PWR) pu++;
      if (wr_valid && cur[2]) push_frame(wr_code);
      if (q.size() > 0) cur = q.pop_front();
      else cur = {3'b100, (pu >= E_PWR), 2'b00};
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  // compare every output away from the active edge
  always @(negedge clk) begin
    if (!rst && started) begin
      chk("R3/R4/R9 dac_cs_n", dac_cs_n, cur[5]);
      chk("R2/R6 dac_sclk",    dac_sclk, cur[4]);
      chk("R5/R10 dac_sdo",    dac_sdo,  cur[3]);
      chk("R1/R7 wr_ready",    wr_ready, cur[2]);
      chk("R8/R9 busy",        busy,     cur[1]);
      chk("R8 done",           done,     cur[0]);
      if (!dac_cs_n && dac_sclk && !cur[4]) rises = rises;
    end
  end

  // count high phases per frame for R6
  logic sclk_d = 1'b0;
  always @(posedge clk) begin
    if (dac_sclk && !sclk_d) rises++;
    sclk_d <= dac_sclk;
  end

  task automatic send(input logic [15:0] c);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_code  = c;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    wr_code  = 16'h0000;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R1
    chk("R1 reset cs_n", dac_cs_n, 1'b1);
    chk("R1 reset sclk", dac_sclk, 1'b0);
    chk("R1 reset ready", wr_ready, 1'b0);
    chk("R8 reset busy", busy, 1'b0);
    rst = 1'b0;
    started = 1'b1;
    // R1: a held request during power-up must not start a frame
    wr_valid = 1'b1;
    wr_code  = 16'h8000;
    repeat (E_PWR - 10) @(negedge clk);
    chk("R1 no frame during power-up", dac_cs_n, 1'b1);
    chk("R1 ready low during power-up", wr_ready, 1'b0);
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    rises = 0;
    wait_idle();
    chk("R6 sixteen rising edges", rises == 16, 1'b1);
    // several patterns, R5
    send(16'hFFFF); wait_idle();
    send(16'h0001); wait_idle();
    send(16'hA5C3); wait_idle();
    send(16'h0000); wait_idle();
    // R7: code offered while busy is not taken and does not disturb the frame
    send(16'h3C5A);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_code  = 16'hFFFF;
    repeat (40) @(negedge clk);
    wr_valid = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R7 offer during busy ignored", dac_cs_n, 1'b1);
    // back-to-back with valid held, R9
    @(negedge clk);
    wr_valid = 1'b1;
    wr_code  = 16'h1234;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_code  = 16'hFEDC;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule